// File: doc/BRIEF.md
# Instruction-Address Breakpoint Trigger

This unit gives a 32-bit core one hardware breakpoint. A debugger in debug mode loads a full instruction address into the compare register and sets the execute-enable bit in the configuration register. From then on, the unit raises a hit whenever the fetch-stage PC equals that address exactly. The hit arrives while the instruction is being fetched, so the core can stop before that instruction runs.

The unit also forms the debug-entry request that the core controller acts on. The request combines three sources: an external halt request, single-step together with a valid instruction, and the breakpoint hit. The unit attaches a cause code to the request. Software reaches the trigger registers through a plain CSR port that carries an address, a write enable, write data, read data and an illegal-access flag.

The compile-time parameter `EnTrig` removes the trigger. With it cleared, every trigger address reports an illegal access and the hit output stays low.

Top module: `brkpt_unit`

## Requirements
- R1: After reset, the configuration register (0x7A1) reads 0x2800_1048, the compare register (0x7A2) reads 0 and `bp_hit_o` is low.
- R2: Addresses 0x7A0, 0x7A3, 0x7A8 and 0x7AA always read 0, and writes to them have no effect. An address outside the six trigger addresses reads 0 and does not raise `csr_illegal_o`.
- R3: The configuration register is a fixed pattern. Only bit 2 (execute enable) is stored, so writing 0xFFFF_FFFF reads back 0x2800_104C and writing 0 reads back 0x2800_1048.
- R4: A write to 0x7A2 stores all 32 bits of the write data. The new value is visible on `csr_rdata_o` from the cycle after the write clock edge.
- R5: A write to 0x7A1 or 0x7A2 while `dbg_mode_i` is low leaves the register unchanged.
- R6: `bp_hit_o` is high exactly when execute enable is set and `fetch_pc_i` equals the compare register in all 32 bits. A PC that differs in bit 0 gives no hit.
- R7: `dbg_enter_o` is high when `dbg_mode_i` is low and at least one of these holds: `halt_req_i` is high, `step_en_i` and `instr_valid_i` are both high, or `bp_hit_o` is high. Single-step without a valid instruction does not request entry.
- R8: When `dbg_enter_o` is high, `dbg_cause_o` is 2 if a breakpoint hit is present. Otherwise it is 4 if a valid single-step is present. Otherwise it is 3 (halt request). When `dbg_enter_o` is low, `dbg_cause_o` is 0.
- R9: With `EnTrig` = 0, all six trigger addresses raise `csr_illegal_o` and read 0, and `bp_hit_o` stays low even after attempted writes in debug mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | CSR write enable |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data for the current address |
| csr_illegal_o | output | 1 | Access to a trigger address while the trigger is compiled out |
| dbg_mode_i | input | 1 | Core is in debug mode |
| fetch_pc_i | input | 32 | Fetch-stage program counter |
| halt_req_i | input | 1 | External halt request |
| step_en_i | input | 1 | Single-step enabled |
| instr_valid_i | input | 1 | Current instruction valid |
| bp_hit_o | output | 1 | Breakpoint address hit |
| dbg_enter_o | output | 1 | Debug-entry request |
| dbg_cause_o | output | 3 | Debug-entry cause code |

## Verification
The bench targets the cause ordering when several entry reasons arrive together. A design with the order wrong would report step or halt while a breakpoint is pending. It also checks that a step without a valid instruction requests nothing; a design that got this wrong would enter debug mode on a flushed slot. Writes issued outside debug mode are read back to show they were dropped; a design that accepted them would let machine-mode code move the breakpoint. A PC one bit away from the target must not hit, and the compiled-out variant must flag all six addresses while never raising a hit.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned CSR_AW = 12;

  localparam logic [CSR_AW-1:0] ADDR_SEL  = 12'h7A0;
  localparam logic [CSR_AW-1:0] ADDR_CFG  = 12'h7A1;
  localparam logic [CSR_AW-1:0] ADDR_CMP  = 12'h7A2;
  localparam logic [CSR_AW-1:0] ADDR_AUX  = 12'h7A3;
  localparam logic [CSR_AW-1:0] ADDR_MCTX = 12'h7A8;
  localparam logic [CSR_AW-1:0] ADDR_SCTX = 12'h7AA;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_TRIG = 3'd2,
    CAUSE_HALT = 3'd3,
    CAUSE_STEP = 3'd4
  } entry_cause_e;

  // Configuration word: every field is fixed except the execute enable bit.
  function automatic logic [XLEN-1:0] cfg_image(input logic exec);
    return {4'h2,      // address/data match kind
            1'b1,      // writable from debug mode only
            6'h00,     // no address masking
            1'b0,      // no hit flag
            1'b0,      // address compare, not data
            1'b0,      // break before execution
            2'b00,     // any access size
            4'h1,      // action: enter debug mode
            1'b0,      // no chaining
            4'h0,      // exact compare
            1'b1,      // active in machine mode
            1'b0,      // reserved
            1'b0,      // no supervisor mode
            1'b1,      // active in user mode
            exec,      // execute enable
            1'b0,      // no store compare
            1'b0};     // no load compare
  endfunction

  function automatic logic is_trig_addr(input logic [CSR_AW-1:0] a);
    return (a == ADDR_SEL) || (a == ADDR_CFG) || (a == ADDR_CMP) ||
           (a == ADDR_AUX) || (a == ADDR_MCTX) || (a == ADDR_SCTX);
  endfunction

  function automatic entry_cause_e pick_cause(input logic hit, input logic step_fire,
                                              input logic halt);
    if (hit)            return CAUSE_TRIG;
    else if (step_fire) return CAUSE_STEP;
    else if (halt)      return CAUSE_HALT;
    else                return CAUSE_NONE;
  endfunction
endpackage

// File: rtl/brkpt_regs.sv
module brkpt_regs
  import brkpt_pkg::*;
#(
  parameter bit          EnTrig = 1'b1,
  parameter int unsigned AW     = CSR_AW,
  parameter int unsigned XW     = XLEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [XW-1:0] wdata_i,
  input  logic          dbg_mode_i,
  output logic          cfg_wr_o,
  output logic          cmp_wr_o,
  output logic          exec_q_o,
  output logic [XW-1:0] value_q_o
);
  localparam int unsigned ExecBit = 2;

  if (EnTrig) begin : g_on
    logic          exec_q;
    logic [XW-1:0] value_q;

    assign cfg_wr_o = we_i & dbg_mode_i & (addr_i == ADDR_CFG);
    assign cmp_wr_o = we_i & dbg_mode_i & (addr_i == ADDR_CMP);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        exec_q <= 1'b0;
      end else if (cfg_wr_o) begin
        exec_q <= wdata_i[ExecBit];
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        value_q <= '0;
      end else if (cmp_wr_o) begin
        value_q <= wdata_i;
      end
    end

    assign exec_q_o  = exec_q;
    assign value_q_o = value_q;
  end else begin : g_off
    logic unused_w;
    assign unused_w  = ^{clk_i, rst_ni, addr_i, we_i, wdata_i, dbg_mode_i};
    assign cfg_wr_o  = 1'b0;
    assign cmp_wr_o  = 1'b0;
    assign exec_q_o  = 1'b0;
    assign value_q_o = '0;
  end
endmodule

// File: rtl/brkpt_readmux.sv
module brkpt_readmux
  import brkpt_pkg::*;
#(
  parameter bit          EnTrig = 1'b1,
  parameter int unsigned AW     = CSR_AW,
  parameter int unsigned XW     = XLEN
) (
  input  logic [AW-1:0] addr_i,
  input  logic          exec_i,
  input  logic [XW-1:0] value_i,
  output logic [XW-1:0] rdata_o,
  output logic          illegal_o
);
  if (EnTrig) begin : g_on
    always_comb begin
      unique case (addr_i)
        ADDR_CFG: rdata_o = cfg_image(exec_i);
        ADDR_CMP: rdata_o = value_i;
        default:  rdata_o = '0;
      endcase
    end
    assign illegal_o = 1'b0;
  end else begin : g_off
    logic unused_w;
    assign unused_w  = ^{exec_i, value_i};
    assign rdata_o   = '0;
    assign illegal_o = is_trig_addr(addr_i);
  end
endmodule

// File: rtl/brkpt_entry.sv
module brkpt_entry
  import brkpt_pkg::*;
(
  input  logic          halt_req_i,
  input  logic          step_en_i,
  input  logic          instr_valid_i,
  input  logic          hit_i,
  input  logic          dbg_mode_i,
  output logic          step_fire_o,
  output logic          enter_o,
  output entry_cause_e  cause_o
);
  assign step_fire_o = step_en_i & instr_valid_i;
  assign enter_o     = (halt_req_i | step_fire_o | hit_i) & ~dbg_mode_i;
  assign cause_o     = enter_o ? pick_cause(hit_i, step_fire_o, halt_req_i) : CAUSE_NONE;
endmodule

// File: rtl/brkpt_unit.sv
module brkpt_unit
  import brkpt_pkg::*;
#(
  parameter bit EnTrig = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CSR_AW-1:0] csr_addr_i,
  input  logic              csr_we_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              csr_illegal_o,
  input  logic              dbg_mode_i,
  input  logic [XLEN-1:0]   fetch_pc_i,
  input  logic              halt_req_i,
  input  logic              step_en_i,
  input  logic              instr_valid_i,
  output logic              bp_hit_o,
  output logic              dbg_enter_o,
  output logic [2:0]        dbg_cause_o
);
  logic            cfg_wr;
  logic            cmp_wr;
  logic            exec_q;
  logic [XLEN-1:0] value_q;
  logic            step_fire;
  entry_cause_e    cause;

  brkpt_regs #(.EnTrig(EnTrig), .AW(CSR_AW), .XW(XLEN)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (csr_addr_i),
    .we_i       (csr_we_i),
    .wdata_i    (csr_wdata_i),
    .dbg_mode_i (dbg_mode_i),
    .cfg_wr_o   (cfg_wr),
    .cmp_wr_o   (cmp_wr),
    .exec_q_o   (exec_q),
    .value_q_o  (value_q)
  );

  brkpt_readmux #(.EnTrig(EnTrig), .AW(CSR_AW), .XW(XLEN)) u_rmux (
    .addr_i    (csr_addr_i),
    .exec_i    (exec_q),
    .value_i   (value_q),
    .rdata_o   (csr_rdata_o),
    .illegal_o (csr_illegal_o)
  );

  if (EnTrig) begin : g_cmp
    assign bp_hit_o = exec_q & (fetch_pc_i == value_q);
  end else begin : g_nocmp
    logic unused_pc;
    assign unused_pc = ^fetch_pc_i;
    assign bp_hit_o  = 1'b0;
  end

  brkpt_entry u_entry (
    .halt_req_i    (halt_req_i),
    .step_en_i     (step_en_i),
    .instr_valid_i (instr_valid_i),
    .hit_i         (bp_hit_o),
    .dbg_mode_i    (dbg_mode_i),
    .step_fire_o   (step_fire),
    .enter_o       (dbg_enter_o),
    .cause_o       (cause)
  );

  assign dbg_cause_o = cause;
endmodule

// File: rtl/brkpt_checker.sv
module brkpt_checker
  import brkpt_pkg::*;
#(
  parameter bit EnTrig = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CSR_AW-1:0] csr_addr_i,
  input logic              csr_we_i,
  input logic [XLEN-1:0]   csr_wdata_i,
  input logic [XLEN-1:0]   csr_rdata_o,
  input logic              csr_illegal_o,
  input logic              dbg_mode_i,
  input logic              halt_req_i,
  input logic              bp_hit_o,
  input logic              dbg_enter_o,
  input logic [2:0]        dbg_cause_o,
  input logic              cfg_wr,
  input logic              cmp_wr,
  input logic [XLEN-1:0]   value_q,
  input logic              step_fire
);
  // R5: compare register ignores writes from outside debug mode
  p_drop_mmode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !dbg_mode_i && csr_addr_i == ADDR_CMP) |=> $stable(value_q));

  // R4: a debug-mode write lands in full
  p_write_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_wr |=> (value_q == $past(csr_wdata_i)));

  // R3: fixed configuration fields
  p_cfg_fixed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (EnTrig && csr_addr_i == ADDR_CFG) |->
      (csr_rdata_o[31:3] == 29'h0500_0209 && csr_rdata_o[1:0] == 2'b00));

  // R7: no entry request while already in debug mode
  p_no_reenter_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_mode_i |-> !dbg_enter_o);

  // R8: breakpoint wins the cause
  p_trig_first_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_hit_o && !dbg_mode_i) |-> (dbg_cause_o == 3'd2));

  // R8: step beats halt
  p_step_over_halt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bp_hit_o && step_fire && halt_req_i && !dbg_mode_i) |-> (dbg_cause_o == 3'd4));

  // R9: illegal flag only for trigger addresses
  p_illegal_scope_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> is_trig_addr(csr_addr_i));

  // R5: write events only in debug mode
  p_wr_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_wr || cmp_wr) |-> dbg_mode_i);
endmodule

bind brkpt_unit brkpt_checker #(.EnTrig(EnTrig)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .csr_addr_i    (csr_addr_i),
  .csr_we_i      (csr_we_i),
  .csr_wdata_i   (csr_wdata_i),
  .csr_rdata_o   (csr_rdata_o),
  .csr_illegal_o (csr_illegal_o),
  .dbg_mode_i    (dbg_mode_i),
  .halt_req_i    (halt_req_i),
  .bp_hit_o      (bp_hit_o),
  .dbg_enter_o   (dbg_enter_o),
  .dbg_cause_o   (dbg_cause_o),
  .cfg_wr        (cfg_wr),
  .cmp_wr        (cmp_wr),
  .value_q       (value_q),
  .step_fire     (step_fire)
);

// File: tb/brkpt_unit_bench.sv
module brkpt_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] csr_addr_i = '0;
  logic        csr_we_i = 1'b0;
  logic [31:0] csr_wdata_i = '0;
  logic        dbg_mode_i = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic        halt_req_i = 1'b0;
  logic        step_en_i = 1'b0;
  logic        instr_valid_i = 1'b0;

  logic [31:0] rdata, rdata_off;
  logic        illegal, illegal_off;
  logic        hit, hit_off;
  logic        enter, enter_off;
  logic [2:0]  cause, cause_off;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] TARGET = 32'h8000_0104;

  always #4 clk_i = ~clk_i;

  brkpt_unit #(.EnTrig(1'b1)) u_brkpt_unit (
    .clk_i, .rst_ni, .csr_addr_i, .csr_we_i, .csr_wdata_i,
    .csr_rdata_o(rdata), .csr_illegal_o(illegal), .dbg_mode_i, .fetch_pc_i,
    .halt_req_i, .step_en_i, .instr_valid_i,
    .bp_hit_o(hit), .dbg_enter_o(enter), .dbg_cause_o(cause)
  );

  brkpt_unit #(.EnTrig(1'b0)) u_brkpt_unit_off (
    .clk_i, .rst_ni, .csr_addr_i, .csr_we_i, .csr_wdata_i,
    .csr_rdata_o(rdata_off), .csr_illegal_o(illegal_off), .dbg_mode_i, .fetch_pc_i,
    .halt_req_i, .step_en_i, .instr_valid_i,
    .bp_hit_o(hit_off), .dbg_enter_o(enter_off), .dbg_cause_o(cause_off)
  );

  // {pc_is_target, halt, step, valid, dbg_mode, exp_enter, exp_cause[2:0]}
  localparam int NV = 10;
  localparam logic [8:0] VEC [NV] = '{
    9'b00000_0_000,
    9'b01000_1_011,
    9'b00110_1_100,
    9'b00100_0_000,
    9'b10000_1_010,
    9'b11110_1_010,
    9'b01110_1_100,
    9'b11001_0_000,
    9'b01111_0_000,
    9'b10100_1_010
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [31:0] d, input logic dm);
    @(negedge clk_i);
    csr_addr_i = a; csr_wdata_i = d; csr_we_i = 1'b1; dbg_mode_i = dm;
    @(negedge clk_i);
    csr_we_i = 1'b0; dbg_mode_i = 1'b0;
  endtask

  task automatic csr_read(input logic [11:0] a, output logic [31:0] d, output logic ill,
                          output logic [31:0] d_off, output logic ill_off);
    @(negedge clk_i);
    csr_addr_i = a;
    #1;
    d = rdata; ill = illegal; d_off = rdata_off; ill_off = illegal_off;
  endtask

  initial begin
    logic [31:0] d, d_off;
    logic ill, ill_off;
    #3 rst_ni = 1'b0;
    #20 rst_ni = 1'b1;

    // R1 reset state
    csr_read(12'h7A1, d, ill, d_off, ill_off); check("R1 cfg reset", d, 32'h2800_1048);
    csr_read(12'h7A2, d, ill, d_off, ill_off); check("R1 cmp reset", d, 32'h0);
    fetch_pc_i = 32'h0; #1 check("R1 no hit at reset", {31'd0, hit}, 32'd0);

    // R9 off variant flags all six
    foreach (VEC[i]) begin end
    begin
      logic [11:0] al [6] = '{12'h7A0, 12'h7A1, 12'h7A2, 12'h7A3, 12'h7A8, 12'h7AA};
      foreach (al[k]) begin
        csr_read(al[k], d, ill, d_off, ill_off);
        check("R9 illegal when off", {31'd0, ill_off}, 32'd1);
        check("R9 read zero when off", d_off, 32'd0);
        check("R2 no illegal when on", {31'd0, ill}, 32'd0);
      end
    end

    // R5 machine-mode writes dropped
    csr_write(12'h7A2, TARGET, 1'b0);
    csr_write(12'h7A1, 32'hFFFF_FFFF, 1'b0);
    csr_read(12'h7A2, d, ill, d_off, ill_off); check("R5 cmp dropped", d, 32'h0);
    csr_read(12'h7A1, d, ill, d_off, ill_off); check("R5 cfg dropped", d, 32'h2800_1048);

    // R4 full write, R3 only execute stored
    csr_write(12'h7A2, 32'hA5C3_0F96, 1'b1);
    csr_read(12'h7A2, d, ill, d_off, ill_off); check("R4 cmp stored", d, 32'hA5C3_0F96);
    csr_write(12'h7A1, 32'hFFFF_FFFF, 1'b1);
    csr_read(12'h7A1, d, ill, d_off, ill_off); check("R3 cfg all ones", d, 32'h2800_104C);
    csr_write(12'h7A1, 32'h0, 1'b1);
    csr_read(12'h7A1, d, ill, d_off, ill_off); check("R3 cfg zero", d, 32'h2800_1048);

    // R2 other addresses stay zero
    csr_write(12'h7A0, 32'hFFFF_FFFF, 1'b1);
    csr_write(12'h7A3, 32'hFFFF_FFFF, 1'b1);
    csr_write(12'h7A8, 32'hFFFF_FFFF, 1'b1);
    csr_write(12'h7AA, 32'hFFFF_FFFF, 1'b1);
    csr_read(12'h7A0, d, ill, d_off, ill_off); check("R2 select zero", d, 32'h0);
    csr_read(12'h7A3, d, ill, d_off, ill_off); check("R2 aux zero", d, 32'h0);
    csr_read(12'h7A8, d, ill, d_off, ill_off); check("R2 mctx zero", d, 32'h0);
    csr_read(12'h7AA, d, ill, d_off, ill_off); check("R2 sctx zero", d, 32'h0);
    csr_read(12'h300, d, ill, d_off, ill_off);
    check("R2 unrelated read", d, 32'h0);
    check("R2 unrelated not illegal", {31'd0, ill}, 32'd0);
    check("R2 unrelated not illegal off", {31'd0, ill_off}, 32'd0);

    // R6 hit needs execute enabled
    csr_write(12'h7A2, TARGET, 1'b1);
    @(negedge clk_i); fetch_pc_i = TARGET; #1;
    check("R6 no hit while disabled", {31'd0, hit}, 32'd0);
    csr_write(12'h7A1, 32'h4, 1'b1);
    @(negedge clk_i); fetch_pc_i = TARGET ^ 32'h1; #1;
    check("R6 near miss", {31'd0, hit}, 32'd0);
    fetch_pc_i = TARGET ^ 32'h8000_0000; #1;
    check("R6 top bit miss", {31'd0, hit}, 32'd0);
    check("R9 off no hit", {31'd0, hit_off}, 32'd0);

    // R7 / R8 table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      fetch_pc_i    = VEC[i][8] ? TARGET : (TARGET + 32'd4);
      halt_req_i    = VEC[i][7];
      step_en_i     = VEC[i][6];
      instr_valid_i = VEC[i][5];
      dbg_mode_i    = VEC[i][4];
      #1;
      check("R6 hit", {31'd0, hit}, {31'd0, VEC[i][8]});
      check("R7 enter", {31'd0, enter}, {31'd0, VEC[i][3]});
      check("R8 cause", {29'd0, cause}, {29'd0, VEC[i][2:0]});
      check("R9 off no hit in table", {31'd0, hit_off}, 32'd0);
    end
    @(negedge clk_i);
    halt_req_i = 1'b0; step_en_i = 1'b0; instr_valid_i = 1'b0; dbg_mode_i = 1'b0;
    fetch_pc_i = TARGET;
    #1 check("R9 off no entry on target", {31'd0, enter_off}, 32'd0);

    // R1 reset again clears the trigger
    @(negedge clk_i); rst_ni = 1'b0; #1; rst_ni = 1'b1;
    #1 check("R1 hit cleared by reset", {31'd0, hit}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule